// File: doc/BRIEF.md
# Synchronizing Register File

This block is a register file where every entry carries a small state tag alongside its payload. The tag makes each entry a single-assignment synchronizing cell. An entry is either empty, waiting or full. When a pipeline read finds an entry full, the data comes back. When the read finds the entry empty, the pipeline does not stall. Instead, the reading thread's identifier is parked in the entry's payload, the entry turns waiting, and the read is reported as a suspension so that thread management can set that thread aside.

Entries are filled through two independent paths. The first is a synchronous pipeline write port. The second is an asynchronous writeback port, which carries the results of long-latency units such as loads and floating-point operations. A third pipeline port marks an entry empty and records which writeback source it now expects. A writeback is accepted only when its source tag matches that expectation and the entry is not already full; any other writeback is refused and reported. Any write that lands on a waiting entry emits a wake-up carrying the parked thread identifier. A pipeline write wakes through one output and a writeback wakes through another, so both can happen in the same cycle.

The state tag is 2 bits: 00 means empty, 01 means waiting (the payload holds a thread ID), and 10 means full (the payload holds data).

Top module: `sync_regfile`

## Requirements
- R1: After reset every entry is empty with an expected writeback source of 0. A read of any entry suspends the reader, and `wbReady` is 1.
- R2: A read of a full entry raises `rdHit` one cycle later, with the stored value on `rdData`.
- R3: A read of an empty entry raises `rdSuspend` one cycle later. The entry becomes waiting and holds the reader's thread ID.
- R4: A pipeline write to a waiting entry raises `wakePipeValid` one cycle later, with the parked ID on `wakePipeThread`. The entry becomes full with the written data.
- R5: A writeback whose `wbSrc` equals the entry's expected source, to an entry that is not full, fills the entry. If the entry was waiting, `wakeWbValid` rises one cycle later with the parked ID on `wakeWbThread`.
- R6: A writeback with a mismatching source, or one aimed at a full entry, raises `wbReject` one cycle after it is applied and leaves the entry unchanged.
- R7: A writeback that targets the same entry as a pipeline write or clear in the same cycle is held. `wbReady` is 0 in the following cycle, and the writeback is applied in that following cycle.
- R8: A read of a waiting entry by a different thread raises `rdError` (not `rdSuspend`) and keeps the parked ID. A re-read by the parked thread itself raises `rdSuspend`.
- R9: A read sees every write, clear and accepted writeback to the same entry in the same cycle. It returns forwarded data, or it parks on the just-cleared entry.
- R10: A clear makes an entry empty and sets its expected source. A pipeline write to the same entry in the same cycle wins, and the clear is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| rdEn | input | 1 | Pipeline read request |
| rdAddr | input | ADDR_W | Entry to read |
| rdThread | input | THREAD_W | ID of the reading thread |
| rdHit | output | 1 | Read found data (registered) |
| rdData | output | DATA_W | Data returned by a hit |
| rdSuspend | output | 1 | Reader was parked in the entry |
| rdError | output | 1 | Entry already held another thread's ID |
| wrEn | input | 1 | Pipeline write |
| wrAddr | input | ADDR_W | Pipeline write entry |
| wrData | input | DATA_W | Pipeline write data |
| clrEn | input | 1 | Mark entry empty, pending a writeback |
| clrAddr | input | ADDR_W | Entry to mark empty |
| clrSrc | input | SRC_W | Writeback source the entry will expect |
| wbValid | input | 1 | Asynchronous writeback present |
| wbReady | output | 1 | Writeback port can take a new writeback |
| wbAddr | input | ADDR_W | Writeback entry |
| wbData | input | DATA_W | Writeback data |
| wbSrc | input | SRC_W | Source tag of the writeback |
| wbReject | output | 1 | Applied writeback was refused |
| wakePipeValid | output | 1 | Pipeline write released a thread |
| wakePipeThread | output | THREAD_W | Thread released by the pipeline write |
| wakeWbValid | output | 1 | Writeback released a thread |
| wakeWbThread | output | THREAD_W | Thread released by the writeback |

## Verification
The key same-cycle overlap is a pipeline read and a fill of the same entry. If the read used the entry's old state, it would park the thread in a cell that is being filled, and the thread would never be woken. The bench provokes this in three ways: a read together with a matching writeback to an empty entry, a read together with a pipeline write, and a read together with a clear of a full entry. It judges the first two by a data hit with no suspension and no wake-up. It judges the third by a suspension, followed by a later write whose wake-up carries the reader's ID. A second overlap, a writeback against a pipeline write or clear to one entry, is judged by the one-cycle drop of `wbReady` and by the held writeback's outcome.

// File: rtl/srf_pkg.sv
package srf_pkg;

  typedef enum logic [1:0] {
    ST_EMPTY = 2'b00,
    ST_WAIT  = 2'b01,
    ST_FULL  = 2'b10
  } regState_e;

  typedef struct packed {
    logic wrApply;
    logic clrApply;
    logic wbApply;
    logic parkApply;
  } srfStrobes_t;

endpackage

// File: rtl/srf_datapath.sv
module srf_datapath
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 32,
  parameter int SRC_W    = 3,
  parameter int THREAD_W = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  srfStrobes_t         strobes,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic [ADDR_W-1:0]   clrAddr,
  input  logic [SRC_W-1:0]    clrSrc,
  input  logic [ADDR_W-1:0]   wbAddr,
  input  logic [DATA_W-1:0]   wbData,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [THREAD_W-1:0] rdThread,
  output regState_e           rdTapState,
  output logic [DATA_W-1:0]   rdTapPay,
  output regState_e           wrTapState,
  output logic [THREAD_W-1:0] wrTapThread,
  output regState_e           wbTapState,
  output logic [THREAD_W-1:0] wbTapThread,
  output logic [SRC_W-1:0]    wbTapSrc
);

  regState_e           stateArr [NUM_REGS];
  logic [DATA_W-1:0]   payArr   [NUM_REGS];
  logic [SRC_W-1:0]    srcArr   [NUM_REGS];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_cell
    regState_e         stQ;
    logic [DATA_W-1:0] payQ;
    logic [SRC_W-1:0]  srcQ;
    logic              hitWr, hitClr, hitWb, hitPark;

    assign hitWr   = strobes.wrApply   && (wrAddr  == ADDR_W'(i));
    assign hitClr  = strobes.clrApply  && (clrAddr == ADDR_W'(i));
    assign hitWb   = strobes.wbApply   && (wbAddr  == ADDR_W'(i));
    assign hitPark = strobes.parkApply && (rdAddr  == ADDR_W'(i));

    always_ff @(posedge clk) begin
      if (!rstN) begin
        stQ  <= ST_EMPTY;
        payQ <= '0;
        srcQ <= '0;
      end else begin
        if (hitWr) begin
          stQ  <= ST_FULL;
          payQ <= wrData;
        end else if (hitClr) begin
          stQ  <= ST_EMPTY;
          srcQ <= clrSrc;
        end else if (hitWb) begin
          stQ  <= ST_FULL;
          payQ <= wbData;
        end
        // parking follows the fills of this cycle and overrides them
        if (hitPark) begin
          stQ  <= ST_WAIT;
          payQ <= DATA_W'(rdThread);
        end
      end
    end

    assign stateArr[i] = stQ;
    assign payArr[i]   = payQ;
    assign srcArr[i]   = srcQ;
  end

  logic [DATA_W-1:0] wrTapPay, wbTapPay;

  assign rdTapState  = stateArr[rdAddr];
  assign rdTapPay    = payArr[rdAddr];
  assign wrTapState  = stateArr[wrAddr];
  assign wrTapPay    = payArr[wrAddr];
  assign wrTapThread = wrTapPay[THREAD_W-1:0];
  assign wbTapState  = stateArr[wbAddr];
  assign wbTapPay    = payArr[wbAddr];
  assign wbTapThread = wbTapPay[THREAD_W-1:0];
  assign wbTapSrc    = srcArr[wbAddr];

endmodule

// File: rtl/srf_control.sv
module srf_control
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 32,
  parameter int SRC_W    = 3,
  parameter int THREAD_W = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [THREAD_W-1:0] rdThread,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                clrEn,
  input  logic [ADDR_W-1:0]   clrAddr,
  input  logic                wbValid,
  input  logic [ADDR_W-1:0]   wbAddr,
  input  logic [DATA_W-1:0]   wbData,
  input  logic [SRC_W-1:0]    wbSrc,
  input  regState_e           rdTapState,
  input  logic [DATA_W-1:0]   rdTapPay,
  input  regState_e           wrTapState,
  input  logic [THREAD_W-1:0] wrTapThread,
  input  regState_e           wbTapState,
  input  logic [THREAD_W-1:0] wbTapThread,
  input  logic [SRC_W-1:0]    wbTapSrc,
  output srfStrobes_t         strobes,
  output logic [ADDR_W-1:0]   wbAddrEff,
  output logic [DATA_W-1:0]   wbDataEff,
  output logic                wbReady,
  output logic                rdHit,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdSuspend,
  output logic                rdError,
  output logic                wbReject,
  output logic                wakePipeValid,
  output logic [THREAD_W-1:0] wakePipeThread,
  output logic                wakeWbValid,
  output logic [THREAD_W-1:0] wakeWbThread
);

  // one-entry slot for a writeback displaced by a pipeline access
  logic              holdValidQ;
  logic [ADDR_W-1:0] holdAddrQ;
  logic [DATA_W-1:0] holdDataQ;
  logic [SRC_W-1:0]  holdSrcQ;

  logic              wbReq, wbClash, wbGo, wbOk, wbBad;
  logic [SRC_W-1:0]  wbSrcEff;
  logic              clrLive;
  regState_e         postState;
  logic [DATA_W-1:0] postPay;
  logic              hitNow, suspendNow, errNow;
  logic              wakePipeNow, wakeWbNow;

  assign wbReady = !holdValidQ;

  always_comb begin
    wbReq     = holdValidQ | wbValid;
    wbAddrEff = holdValidQ ? holdAddrQ : wbAddr;
    wbDataEff = holdValidQ ? holdDataQ : wbData;
    wbSrcEff  = holdValidQ ? holdSrcQ  : wbSrc;

    wbClash = wbReq && ((wrEn  && (wrAddr  == wbAddrEff)) ||
                        (clrEn && (clrAddr == wbAddrEff)));
    wbGo    = wbReq && !wbClash;
    wbOk    = wbGo && (wbTapState != ST_FULL) && (wbTapSrc == wbSrcEff);
    wbBad   = wbGo && !wbOk;

    clrLive = clrEn && !(wrEn && (wrAddr == clrAddr));

    // state the read entry holds once this cycle's fills have landed
    if (wrEn && (wrAddr == rdAddr)) begin
      postState = ST_FULL;
      postPay   = wrData;
    end else if (clrLive && (clrAddr == rdAddr)) begin
      postState = ST_EMPTY;
      postPay   = rdTapPay;
    end else if (wbOk && (wbAddrEff == rdAddr)) begin
      postState = ST_FULL;
      postPay   = wbDataEff;
    end else begin
      postState = rdTapState;
      postPay   = rdTapPay;
    end

    hitNow     = rdEn && (postState == ST_FULL);
    suspendNow = rdEn && ((postState == ST_EMPTY) ||
                          ((postState == ST_WAIT) && (postPay[THREAD_W-1:0] == rdThread)));
    errNow     = rdEn && (postState == ST_WAIT) && (postPay[THREAD_W-1:0] != rdThread);

    wakePipeNow = wrEn && (wrTapState == ST_WAIT);
    wakeWbNow   = wbOk && (wbTapState == ST_WAIT);

    strobes.wrApply   = wrEn;
    strobes.clrApply  = clrLive;
    strobes.wbApply   = wbOk;
    strobes.parkApply = rdEn && (postState == ST_EMPTY);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      holdValidQ <= 1'b0;
      holdAddrQ  <= '0;
      holdDataQ  <= '0;
      holdSrcQ   <= '0;
    end else begin
      holdValidQ <= wbClash;
      if (wbClash) begin
        holdAddrQ <= wbAddrEff;
        holdDataQ <= wbDataEff;
        holdSrcQ  <= wbSrcEff;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rdHit          <= 1'b0;
      rdData         <= '0;
      rdSuspend      <= 1'b0;
      rdError        <= 1'b0;
      wbReject       <= 1'b0;
      wakePipeValid  <= 1'b0;
      wakePipeThread <= '0;
      wakeWbValid    <= 1'b0;
      wakeWbThread   <= '0;
    end else begin
      rdHit          <= hitNow;
      rdData         <= hitNow ? postPay : '0;
      rdSuspend      <= suspendNow;
      rdError        <= errNow;
      wbReject       <= wbBad;
      wakePipeValid  <= wakePipeNow;
      wakePipeThread <= wakePipeNow ? wrTapThread : '0;
      wakeWbValid    <= wakeWbNow;
      wakeWbThread   <= wakeWbNow ? wbTapThread : '0;
    end
  end

endmodule

// File: rtl/sync_regfile.sv
module sync_regfile
  import srf_pkg::*;
#(
  parameter int NUM_REGS = 64,
  parameter int DATA_W   = 32,
  parameter int SRC_W    = 3,
  parameter int THREAD_W = 8,
  localparam int ADDR_W  = $clog2(NUM_REGS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                rdEn,
  input  logic [ADDR_W-1:0]   rdAddr,
  input  logic [THREAD_W-1:0] rdThread,
  output logic                rdHit,
  output logic [DATA_W-1:0]   rdData,
  output logic                rdSuspend,
  output logic                rdError,
  input  logic                wrEn,
  input  logic [ADDR_W-1:0]   wrAddr,
  input  logic [DATA_W-1:0]   wrData,
  input  logic                clrEn,
  input  logic [ADDR_W-1:0]   clrAddr,
  input  logic [SRC_W-1:0]    clrSrc,
  input  logic                wbValid,
  output logic                wbReady,
  input  logic [ADDR_W-1:0]   wbAddr,
  input  logic [DATA_W-1:0]   wbData,
  input  logic [SRC_W-1:0]    wbSrc,
  output logic                wbReject,
  output logic                wakePipeValid,
  output logic [THREAD_W-1:0] wakePipeThread,
  output logic                wakeWbValid,
  output logic [THREAD_W-1:0] wakeWbThread
);

  srfStrobes_t         strobes;
  logic [ADDR_W-1:0]   wbAddrEff;
  logic [DATA_W-1:0]   wbDataEff;
  regState_e           rdTapState, wrTapState, wbTapState;
  logic [DATA_W-1:0]   rdTapPay;
  logic [THREAD_W-1:0] wrTapThread, wbTapThread;
  logic [SRC_W-1:0]    wbTapSrc;

  srf_control #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SRC_W(SRC_W), .THREAD_W(THREAD_W)
  ) u_control (
    .clk(clk), .rstN(rstN),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdThread(rdThread),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clrEn(clrEn), .clrAddr(clrAddr),
    .wbValid(wbValid), .wbAddr(wbAddr), .wbData(wbData), .wbSrc(wbSrc),
    .rdTapState(rdTapState), .rdTapPay(rdTapPay),
    .wrTapState(wrTapState), .wrTapThread(wrTapThread),
    .wbTapState(wbTapState), .wbTapThread(wbTapThread), .wbTapSrc(wbTapSrc),
    .strobes(strobes), .wbAddrEff(wbAddrEff), .wbDataEff(wbDataEff),
    .wbReady(wbReady),
    .rdHit(rdHit), .rdData(rdData), .rdSuspend(rdSuspend), .rdError(rdError),
    .wbReject(wbReject),
    .wakePipeValid(wakePipeValid), .wakePipeThread(wakePipeThread),
    .wakeWbValid(wakeWbValid), .wakeWbThread(wakeWbThread)
  );

  srf_datapath #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SRC_W(SRC_W), .THREAD_W(THREAD_W)
  ) u_datapath (
    .clk(clk), .rstN(rstN), .strobes(strobes),
    .wrAddr(wrAddr), .wrData(wrData),
    .clrAddr(clrAddr), .clrSrc(clrSrc),
    .wbAddr(wbAddrEff), .wbData(wbDataEff),
    .rdAddr(rdAddr), .rdThread(rdThread),
    .rdTapState(rdTapState), .rdTapPay(rdTapPay),
    .wrTapState(wrTapState), .wrTapThread(wrTapThread),
    .wbTapState(wbTapState), .wbTapThread(wbTapThread), .wbTapSrc(wbTapSrc)
  );

endmodule

// File: rtl/srf_checker.sv
module srf_checker (
  input logic clk,
  input logic rstN,
  input logic rdEn,
  input logic rdHit,
  input logic rdSuspend,
  input logic rdError,
  input logic wrEn,
  input logic clrEn,
  input logic wbValid,
  input logic wbReady,
  input logic wbReject,
  input logic wakePipeValid,
  input logic wakeWbValid
);

  p_one_read_outcome_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({rdHit, rdSuspend, rdError}));

  p_outcome_needs_read_r2: assert property (@(posedge clk) disable iff (!rstN)
    (rdHit || rdSuspend || rdError) |-> $past(rdEn));

  p_pipe_wake_needs_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    wakePipeValid |-> $past(wrEn));

  p_wb_outcome_needs_request_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wakeWbValid || wbReject) |-> $past(wbValid || !wbReady));

  p_wb_wake_or_reject_r6: assert property (@(posedge clk) disable iff (!rstN)
    wakeWbValid |-> !wbReject);

  p_hold_caused_by_clash_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wbReady |-> $past((wbValid || !wbReady) && (wrEn || clrEn)));

  p_hold_drains_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!wbReady && !wrEn && !clrEn) |=> wbReady);

endmodule

bind sync_regfile srf_checker u_srf_checker (
  .clk(clk), .rstN(rstN), .rdEn(rdEn), .rdHit(rdHit), .rdSuspend(rdSuspend),
  .rdError(rdError), .wrEn(wrEn), .clrEn(clrEn), .wbValid(wbValid),
  .wbReady(wbReady), .wbReject(wbReject), .wakePipeValid(wakePipeValid),
  .wakeWbValid(wakeWbValid)
);

// File: tb/sync_regfile_bench.sv
module sync_regfile_bench;

  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 5000;
  localparam int NUM_REGS   = 64;
  localparam int DATA_W     = 32;
  localparam int SRC_W      = 3;
  localparam int THREAD_W   = 8;
  localparam int ADDR_W     = $clog2(NUM_REGS);

  logic                clk = 1'b0;
  logic                rstN;
  logic                rdEn, wrEn, clrEn, wbValid;
  logic [ADDR_W-1:0]   rdAddr, wrAddr, clrAddr, wbAddr;
  logic [THREAD_W-1:0] rdThread;
  logic [DATA_W-1:0]   wrData, wbData;
  logic [SRC_W-1:0]    clrSrc, wbSrc;
  logic                rdHit, rdSuspend, rdError, wbReady, wbReject;
  logic [DATA_W-1:0]   rdData;
  logic                wakePipeValid, wakeWbValid;
  logic [THREAD_W-1:0] wakePipeThread, wakeWbThread;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sync_regfile #(
    .NUM_REGS(NUM_REGS), .DATA_W(DATA_W), .SRC_W(SRC_W), .THREAD_W(THREAD_W)
  ) u_sync_regfile (
    .clk(clk), .rstN(rstN),
    .rdEn(rdEn), .rdAddr(rdAddr), .rdThread(rdThread),
    .rdHit(rdHit), .rdData(rdData), .rdSuspend(rdSuspend), .rdError(rdError),
    .wrEn(wrEn), .wrAddr(wrAddr), .wrData(wrData),
    .clrEn(clrEn), .clrAddr(clrAddr), .clrSrc(clrSrc),
    .wbValid(wbValid), .wbReady(wbReady), .wbAddr(wbAddr), .wbData(wbData),
    .wbSrc(wbSrc), .wbReject(wbReject),
    .wakePipeValid(wakePipeValid), .wakePipeThread(wakePipeThread),
    .wakeWbValid(wakeWbValid), .wakeWbThread(wakeWbThread)
  );

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    rdEn = 0; wrEn = 0; clrEn = 0; wbValid = 0;
    rdAddr = '0; wrAddr = '0; clrAddr = '0; wbAddr = '0;
    rdThread = '0; wrData = '0; wbData = '0; clrSrc = '0; wbSrc = '0;
  endtask

  // inputs are driven at a falling edge; one tick crosses a rising edge
  task automatic tick();
    @(negedge clk);
    idle();
  endtask

  task automatic setRead(input int a, input int t);
    rdEn = 1; rdAddr = ADDR_W'(a); rdThread = THREAD_W'(t);
  endtask
  task automatic setWrite(input int a, input logic [DATA_W-1:0] d);
    wrEn = 1; wrAddr = ADDR_W'(a); wrData = d;
  endtask
  task automatic setClear(input int a, input int s);
    clrEn = 1; clrAddr = ADDR_W'(a); clrSrc = SRC_W'(s);
  endtask
  task automatic setWb(input int a, input logic [DATA_W-1:0] d, input int s);
    wbValid = 1; wbAddr = ADDR_W'(a); wbData = d; wbSrc = SRC_W'(s);
  endtask

  task automatic testReset();
    chk("R1 wbReady after reset", wbReady, 1);
    chk("R1 no read outcome after reset", {rdHit, rdSuspend, rdError}, 0);
    chk("R1 no wake after reset", {wakePipeValid, wakeWbValid}, 0);
    setRead(5, 3); tick();
    chk("R1 read of reset entry suspends", rdSuspend, 1);
    chk("R3 suspend not hit", rdHit, 0);
    setWrite(5, 32'hAA); tick();
    chk("R4 pipe wake valid", wakePipeValid, 1);
    chk("R4 pipe wake thread", wakePipeThread, 3);
    setRead(5, 7); tick();
    chk("R2 hit after write", rdHit, 1);
    chk("R2 hit data", rdData, 32'hAA);
    setWb(6, 32'h5, 0); tick();
    chk("R1 default source 0 accepted", wbReject, 0);
    setRead(6, 2); tick();
    chk("R5 writeback filled entry", rdData, 32'h5);
  endtask

  task automatic testPark();
    setClear(10, 2); tick();
    setRead(10, 9); tick();
    chk("R3 empty read suspends", rdSuspend, 1);
    setRead(10, 9); tick();
    chk("R8 same thread re-read suspends", {rdSuspend, rdError}, 2'b10);
    setRead(10, 4); tick();
    chk("R8 other thread flagged", {rdSuspend, rdError}, 2'b01);
    setWb(10, 32'h55, 2); tick();
    chk("R5 wb wake valid", wakeWbValid, 1);
    chk("R8 parked id kept", wakeWbThread, 9);
    chk("R5 no reject", wbReject, 0);
    setRead(10, 1); tick();
    chk("R5 data after wb", rdData, 32'h55);
  endtask

  task automatic testReject();
    setClear(12, 5); tick();
    setWb(12, 32'h66, 6); tick();
    chk("R6 wrong source rejected", wbReject, 1);
    chk("R6 no wake on reject", wakeWbValid, 0);
    setRead(12, 1); tick();
    chk("R6 entry still empty", rdSuspend, 1);
    setWb(12, 32'h77, 5); tick();
    chk("R5 right source wakes", wakeWbThread, 1);
    setWb(12, 32'h88, 5); tick();
    chk("R6 full entry rejects", wbReject, 1);
    setRead(12, 1); tick();
    chk("R6 full entry unchanged", rdData, 32'h77);
  endtask

  task automatic testCollide();
    setClear(21, 4); setWb(21, 32'h33, 4); tick();
    chk("R7 held after clear clash", wbReady, 0);
    chk("R7 no reject while held", wbReject, 0);
    tick();
    chk("R7 ready after release", wbReady, 1);
    chk("R7 held wb accepted", wbReject, 0);
    setRead(21, 1); tick();
    chk("R7 held data landed", rdData, 32'h33);
    setClear(22, 3); tick();
    setWrite(22, 32'h11); setWb(22, 32'h22, 3); tick();
    chk("R7 held after write clash", wbReady, 0);
    tick();
    chk("R7 held wb meets full entry", wbReject, 1);
    setRead(22, 1); tick();
    chk("R7 pipeline data kept", rdData, 32'h11);
  endtask

  task automatic testForward();
    setClear(30, 1); tick();
    setRead(30, 6); setWb(30, 32'h44, 1); tick();
    chk("R9 read sees same-cycle wb", {rdHit, rdSuspend}, 2'b10);
    chk("R9 forwarded wb data", rdData, 32'h44);
    chk("R9 no wake from empty", wakeWbValid, 0);
    setRead(31, 2); setWrite(31, 32'h99); tick();
    chk("R9 forwarded write data", rdData, 32'h99);
    setRead(31, 8); setClear(31, 0); tick();
    chk("R9 read parks on cleared entry", rdSuspend, 1);
    setWrite(31, 32'hAB); tick();
    chk("R10 wake after clear+park", wakePipeThread, 8);
    setWrite(40, 32'h12); setClear(40, 2); tick();
    setRead(40, 3); tick();
    chk("R10 write beats clear", rdData, 32'h12);
  endtask

  initial begin
    idle();
    rstN = 0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    testReset();
    testPark();
    testReject();
    testCollide();
    testForward();
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule